// File: doc/BRIEF.md
# Supply Start-up and Auto-Restart Sequencer

This block runs the supply life cycle of an offline switching controller. Its inputs are comparator flags that have already been digitized: input bulk voltage present, VDD above turn-on, VDD below turn-off and VDD below the deep restart level. It also takes an extra-power timer voltage flag, a fault shutdown request (with a cause bit) and a millisecond tick. From these it drives three things: the high-voltage charge source (enable plus a reduced-current select), the switching enable, and a soft-start current-limit code.

A normal start charges VDD with the full current until the turn-on level is reached. Switching then begins and the current-limit code ramps up in equal steps. When switching stops with the input still present, recharging waits for VDD to collapse to the restart level. If the stop was caused by a fault, the recharge uses the reduced current, which gives a slow hiccup repetition. If switching stops with the input gone, the sequencer parks in a power-down state and makes no further attempts. It leaves that state only once VDD has fully collapsed.

Top module: `supply_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, chg_en, chg_low and sw_en are 0 and ilim_code is 0.
- R2: chg_en is 1 only while vin_ok is 1. From the idle state, vin_ok=1 starts charging in the next cycle. If vin_ok drops while charging, the block returns to idle.
- R3: chg_low=0 (full current) on a charge that follows idle. After a shutdown with fault_req=1, every recharge has chg_low=1 until a soft-start completes to full scale.
- R4: While charging, vdd_above_on=1 turns chg_en off and sw_en on in the next cycle, with ilim_code=0.
- R5: During soft-start, each cycle with ms_tick=1 raises ilim_code by STEP (default 2), saturating at all ones (15 for CODE_W=4).
- R6: The cycle after ilim_code reaches full scale, the block enters run. There sw_en stays 1 and ilim_code holds full scale regardless of ticks.
- R7: While switching, vdd_below_off=1 or fault_req=1 makes sw_en 0 and ilim_code 0 in the next cycle.
- R8: If vin_ok=0 after switching stops, the block enters power-down. There chg_en stays 0 whatever vin_ok does, until vdd_below_rst=1 returns it to idle.
- R9: After switching stops with vin_ok=1, charging restarts only in the cycle after vdd_below_rst=1.
- R10: If fault_req=1 with fault_xp=1 (extra-power timer cause), the restart also needs xp_below_rst=1 in the same cycle as vdd_below_rst=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| vin_ok | input | 1 | Input bulk voltage above drain start level |
| vdd_above_on | input | 1 | VDD above turn-on level |
| vdd_below_off | input | 1 | VDD below turn-off level |
| vdd_below_rst | input | 1 | VDD below deep restart level |
| xp_below_rst | input | 1 | Extra-power timer voltage below its restart level |
| fault_req | input | 1 | Fault shutdown request |
| fault_xp | input | 1 | Fault cause is the extra-power timer (1) or other (0) |
| chg_en | output | 1 | High-voltage charge source enable |
| chg_low | output | 1 | Reduced charge current select |
| sw_en | output | 1 | Power switch enable |
| ilim_code | output | CODE_W | Soft-start current-limit code |

## Verification
State-driven results (sw_en, ilim_code, chg_low and the charge state) change one clock after the edge that samples the inputs. chg_en is additionally gated by vin_ok in the same cycle. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares all outputs on the next falling edge against a bench model advanced at that same rising edge. Because inputs are already stable at the edge where the model steps, each expected value is due exactly one edge after its stimulus.

// File: rtl/supply_sequencer.sv
module supply_sequencer #(
  parameter int CODE_W = 4,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              vin_ok,
  input  logic              vdd_above_on,
  input  logic              vdd_below_off,
  input  logic              vdd_below_rst,
  input  logic              xp_below_rst,
  input  logic              fault_req,
  input  logic              fault_xp,
  output logic              chg_en,
  output logic              chg_low,
  output logic              sw_en,
  output logic [CODE_W-1:0] ilim_code
);
  localparam int SUM_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] FULL = '1;

  typedef enum logic [2:0] {S_OFF, S_CHG, S_SS, S_RUN, S_DIS, S_PD} st_t;

  st_t st, nx;
  logic hic, xpw;
  logic [CODE_W-1:0] lim;
  logic [SUM_W-1:0]  sum;
  logic [CODE_W-1:0] lim_inc;
  logic stop, rearm;

  assign stop    = vdd_below_off | fault_req;
  assign rearm   = vdd_below_rst & (~xpw | xp_below_rst);
  assign sum     = {1'b0, lim} + SUM_W'(STEP);
  assign lim_inc = (sum > {1'b0, FULL}) ? FULL : sum[CODE_W-1:0];

  always_comb begin
    nx = st;
    unique case (st)
      S_OFF:   if (vin_ok) nx = S_CHG;
      S_CHG:   if (!vin_ok) nx = S_OFF; else if (vdd_above_on) nx = S_SS;
      S_SS:    if (stop) nx = S_DIS; else if (lim == FULL) nx = S_RUN;
      S_RUN:   if (stop) nx = S_DIS;
      S_DIS:   if (!vin_ok) nx = S_PD; else if (rearm) nx = S_CHG;
      S_PD:    if (vdd_below_rst) nx = S_OFF;
      default: nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      lim <= '0;
      hic <= 1'b0;
      xpw <= 1'b0;
    end else begin
      st <= nx;
      if (st == S_SS) begin
        if (ms_tick) lim <= lim_inc;
      end else if (st != S_RUN) begin
        lim <= '0;
      end
      if (st == S_OFF) hic <= 1'b0;
      else if ((st == S_SS || st == S_RUN) && fault_req) hic <= 1'b1;
      else if (st == S_SS && nx == S_RUN) hic <= 1'b0;
      if (st == S_OFF || (st == S_DIS && nx == S_CHG)) xpw <= 1'b0;
      else if ((st == S_SS || st == S_RUN) && fault_req && fault_xp) xpw <= 1'b1;
    end
  end

  assign chg_en    = (st == S_CHG) & vin_ok;
  assign chg_low   = chg_en & hic;
  assign sw_en     = (st == S_SS) | (st == S_RUN);
  assign ilim_code = sw_en ? lim : '0;

  p_start_needs_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(vdd_above_on));
  p_stop_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> $past(vdd_below_off | fault_req));
  p_ramp_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en)) |-> (ilim_code >= $past(ilim_code)));
  p_rearm_deep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_DIS && st == S_CHG) |-> $past(vdd_below_rst));
  p_rearm_xp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_DIS && st == S_CHG && $past(xpw)) |-> $past(xp_below_rst));
  p_pd_no_charge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_PD) |-> (st == S_PD || st == S_OFF));
  p_charge_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |-> !sw_en);
endmodule

// File: tb/sim_supply_sequencer.sv
module sim_supply_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, vin = 0, von = 0, voff = 0, vrst = 0, xpl = 0, flt = 0, fxp = 0;
  logic chg_en, chg_low, sw_en;
  logic [3:0] ilim;
  int errors = 0, checks = 0;
  int m_st = 0, m_lim = 0;
  bit m_hic = 0, m_xpw = 0;

  always #2 clk = ~clk;

  supply_sequencer #(.CODE_W(4), .STEP(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(tick), .vin_ok(vin), .vdd_above_on(von),
    .vdd_below_off(voff), .vdd_below_rst(vrst), .xp_below_rst(xpl),
    .fault_req(flt), .fault_xp(fxp), .chg_en(chg_en), .chg_low(chg_low),
    .sw_en(sw_en), .ilim_code(ilim));

  function automatic int sat_add(int l);
    return (l + 2 > 15) ? 15 : l + 2;
  endfunction

  task automatic mdl_step();
    int n = m_st;
    bit stp = voff | flt;
    case (m_st)
      0: if (vin) n = 1;
      1: if (!vin) n = 0; else if (von) n = 2;
      2: if (stp) n = 4; else if (m_lim == 15) n = 3;
      3: if (stp) n = 4;
      4: if (!vin) n = 5; else if (vrst && (!m_xpw || xpl)) n = 1;
      default: if (vrst) n = 0;
    endcase
    if (m_st == 0) m_hic = 0;
    else if ((m_st == 2 || m_st == 3) && flt) m_hic = 1;
    else if (m_st == 2 && n == 3) m_hic = 0;
    if (m_st == 0 || (m_st == 4 && n == 1)) m_xpw = 0;
    else if ((m_st == 2 || m_st == 3) && flt && fxp) m_xpw = 1;
    if (m_st == 2) begin
      if (tick) m_lim = sat_add(m_lim);
    end else if (m_st != 3) m_lim = 0;
    m_st = n;
  endtask

  task automatic check_model(string tag);
    bit e_chg = (m_st == 1) && vin;
    bit e_low = e_chg && m_hic;
    bit e_sw = (m_st == 2 || m_st == 3);
    int e_lim = e_sw ? m_lim : 0;
    checks++;
    if (chg_en !== e_chg || chg_low !== e_low || sw_en !== e_sw || int'(ilim) != e_lim) begin
      errors++;
      $display("FAIL %s: got chg=%b low=%b sw=%b lim=%0d, want chg=%b low=%b sw=%b lim=%0d",
               tag, chg_en, chg_low, sw_en, ilim, e_chg, e_low, e_sw, e_lim);
    end
  endtask

  task automatic expect4(string tag, bit c, bit l, bit s, int lim);
    checks++;
    if (chg_en !== c || chg_low !== l || sw_en !== s || int'(ilim) != lim) begin
      errors++;
      $display("FAIL %s: got chg=%b low=%b sw=%b lim=%0d, want chg=%b low=%b sw=%b lim=%0d",
               tag, chg_en, chg_low, sw_en, ilim, c, l, s, lim);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    mdl_step();
    @(negedge clk);
    check_model(tag);
  endtask

  initial begin
    #700000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect4("R1 in reset", 0, 0, 0, 0);
    rst_n = 1;
    cyc("R1"); expect4("R1 after reset", 0, 0, 0, 0);
    vin = 1; cyc("R2"); expect4("R2 charge on", 1, 0, 0, 0);
    vin = 0; #0; expect4("R2 gated same cycle", 0, 0, 0, 0);
    cyc("R2"); vin = 1; cyc("R2");
    von = 1; cyc("R4"); expect4("R4 switch on", 0, 0, 1, 0);
    von = 0; tick = 1;
    for (int i = 1; i <= 8; i++) begin
      cyc("R5"); expect4("R5 ramp", 0, 0, 1, (2 * i > 15) ? 15 : 2 * i);
    end
    cyc("R6"); expect4("R6 run", 0, 0, 1, 15);
    cyc("R6"); tick = 0;
    flt = 1; fxp = 1; cyc("R7"); expect4("R7 fault stop", 0, 0, 0, 0);
    flt = 0; fxp = 0;
    vrst = 1; cyc("R10"); expect4("R10 held by xp", 0, 0, 0, 0);
    xpl = 1; cyc("R10"); expect4("R10 rearm low current R3", 1, 1, 0, 0);
    vrst = 0; xpl = 0; von = 1; cyc("R4"); von = 0;
    voff = 1; cyc("R7"); expect4("R7 uv stop", 0, 0, 0, 0); voff = 0;
    repeat (3) begin cyc("R9"); expect4("R9 wait deep", 0, 0, 0, 0); end
    vrst = 1; cyc("R9"); expect4("R9 rearm keeps low R3", 1, 1, 0, 0);
    vrst = 0; von = 1; cyc("R4"); von = 0; tick = 1;
    repeat (9) cyc("R5");
    tick = 0; voff = 1; cyc("R7"); voff = 0;
    vin = 0; cyc("R8"); vin = 1; cyc("R8"); expect4("R8 powerdown", 0, 0, 0, 0);
    cyc("R8"); expect4("R8 powerdown hold", 0, 0, 0, 0);
    vrst = 1; cyc("R8"); expect4("R8 back to idle", 0, 0, 0, 0);
    vrst = 0; cyc("R3"); expect4("R3 full current after idle", 1, 0, 0, 0);
    void'($urandom(32'd12345));
    for (int i = 0; i < 4000; i++) begin
      vin  = ($urandom % 16) != 0;
      von  = ($urandom % 4) == 0;
      voff = ($urandom % 24) == 0;
      vrst = ($urandom % 6) == 0;
      xpl  = ($urandom % 3) == 0;
      flt  = ($urandom % 30) == 0;
      fxp  = $urandom % 2;
      tick = ($urandom % 3) == 0;
      cyc("R2 R3 R5 R7 R8 R9 R10 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule